// File: doc/BRIEF.md
# Turbo Decoder Parallelism and Iteration Selector

This block chooses, at run time, how a multi-processor turbo decoder should be set up for its next frame. It answers three questions: how many sub-blocks to split the frame into, whether the two component decoders run one after the other (serial) or at the same time (shuffled), and how many decoding iterations to run. The iteration estimate grows with the split factor. It is the base count for the channel condition plus the split factor divided by a threshold, rounded up. Shuffled decoding adds a fixed penalty on top. Both the base count and the threshold come from a small writable table indexed by an SNR class and an error-rate objective.

After a `start` pulse, the engine latches its inputs and the selected table entry. It then tries split factors 1, 2, 4 and so on up to the maximum, one candidate per clock. At each split factor it tries serial before shuffled. It stops at the first candidate whose throughput reaches the target, so the decoder uses the fewest processors that will do the job. If no candidate reaches the target, it reports the error-rate-safe configuration at maximum parallelism and raises a fallback flag. It also reports the decoding latency of the chosen configuration in clock cycles.

Top module: `psel_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, `par` is 1, `nproc` is 2, and `fallback`, `shuffled`, `iters` and `latency` are 0.
- R2: For a candidate with split factor P, the iteration count is base + ceil(P/T), plus `SHUF_PEN` (default 1) in shuffled mode. A stored threshold T of 0 is treated as 1.
- R3: A candidate meets the target when fclk_mhz·P·m ≥ tgt_mbps·4·iters, where m is 1 for serial and 2 for shuffled.
- R4: Candidates are visited in this order: P = 1, 2, 4, …, 2^PMAX_LOG2. At each P, serial comes before shuffled. The first candidate that meets the target is reported, with `shuffled` = 1 for shuffled mode.
- R5: If no candidate meets the target, the result is P = 2^PMAX_LOG2 in shuffled mode with that candidate's iteration count, and `fallback` = 1. Otherwise `fallback` = 0.
- R6: `nproc` always equals 2·`par`.
- R7: `latency` = ceil(4·iters·floor(frame_bits/2)/P) + 10.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until the cycle of `done`. The result outputs change only on the `done` cycle and hold until the next one.
- R9: A `start` pulse while `busy` is high is ignored and does not change the search in progress.
- R10: The table is written with `tbl_we` at entry (`tbl_snr`, `tbl_ber`). A write in the same cycle as an accepted `start` that reads the same entry does not affect that search; the new contents apply from the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_snr | input | SNRW | SNR class of the entry to write |
| tbl_ber | input | BERW | Error-rate objective of the entry to write |
| tbl_base | input | BW | Base iteration count to store |
| tbl_thr | input | BW | Threshold to store |
| start | input | 1 | Begin a search (accepted only when idle) |
| snr_idx | input | SNRW | SNR class for the search |
| ber_idx | input | BERW | Error-rate objective for the search |
| frame_bits | input | FW | Frame size in bits |
| fclk_mhz | input | CW | Decoder clock frequency |
| tgt_mbps | input | CW | Throughput target |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| par | output | PW | Chosen split factor P |
| nproc | output | PW+1 | Processor count, 2·P |
| iters | output | ITW | Chosen iteration count |
| shuffled | output | 1 | 1 = shuffled, 0 = serial |
| fallback | output | 1 | No candidate met the target |
| latency | output | 32 | Decoding latency in cycles |

## Verification
Two events can land in the same cycle: a table write and an accepted start that reads the entry being written. The bench forces them together. It expects that search to use the old entry and the following search to use the new one. It also pulses `start` again in the middle of a search with a target that would give a different answer. That result must match the first request alone, and the outputs must stay unchanged between `done` strobes.

// File: rtl/psel_pkg.sv
package psel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_LAT  = 2'd2
    } psel_st_e;
endpackage

// File: rtl/psel_table.sv
module psel_table #(
    parameter int NSNR = 4,
    parameter int NBER = 4,
    parameter int BW   = 8,
    localparam int DEPTH = NSNR * NBER,
    localparam int AW    = $clog2(DEPTH),
    localparam int SNRW  = (NSNR > 1) ? $clog2(NSNR) : 1,
    localparam int BERW  = (NBER > 1) ? $clog2(NBER) : 1
) (
    input  logic            clk,
    input  logic            we,
    input  logic [SNRW-1:0] wsnr,
    input  logic [BERW-1:0] wber,
    input  logic [BW-1:0]   wbase,
    input  logic [BW-1:0]   wthr,
    input  logic [SNRW-1:0] rsnr,
    input  logic [BERW-1:0] rber,
    output logic [BW-1:0]   rbase,
    output logic [BW-1:0]   rthr
);
    logic [2*BW-1:0] mem [DEPTH];
    logic [AW-1:0]   waddr;
    logic [AW-1:0]   raddr;

    assign waddr = AW'(int'(wsnr) * NBER + int'(wber));
    assign raddr = AW'(int'(rsnr) * NBER + int'(rber));

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= {wbase, wthr};
    end

    assign rbase = mem[raddr][2*BW-1:BW];
    assign rthr  = mem[raddr][BW-1:0];
endmodule

// File: rtl/psel_eval.sv
module psel_eval #(
    parameter int BW     = 8,
    parameter int PW     = 5,
    parameter int CW     = 16,
    parameter int NINSTR = 4,
    parameter int PEN    = 1,
    localparam int ITW   = BW + 2,
    localparam int DW    = ((BW > PW) ? BW : PW) + 1,
    localparam int MW    = 64
) (
    input  logic [BW-1:0]  base,
    input  logic [BW-1:0]  thr,
    input  logic [PW-1:0]  par,
    input  logic           shuf,
    input  logic [CW-1:0]  fclk,
    input  logic [CW-1:0]  tgt,
    output logic [ITW-1:0] niter,
    output logic           meets
);
    logic [BW-1:0] thr_eff;
    logic [DW-1:0] num;
    logic [DW-1:0] quo;
    logic [MW-1:0] lhs;
    logic [MW-1:0] rhs;

    always_comb begin
        thr_eff = (thr == '0) ? BW'(1) : thr;
        num     = DW'(par) + DW'(thr_eff) - DW'(1);
        quo     = num / DW'(thr_eff);
        niter   = ITW'(base) + ITW'(quo) + (shuf ? ITW'(PEN) : ITW'(0));
        lhs     = MW'(fclk) * MW'(par) * (shuf ? MW'(2) : MW'(1));
        rhs     = MW'(tgt) * MW'(NINSTR) * MW'(niter);
        meets   = (lhs >= rhs);
    end
endmodule

// File: rtl/psel_lat.sv
module psel_lat #(
    parameter int ITW    = 10,
    parameter int FW     = 16,
    parameter int KW     = 3,
    parameter int NINSTR = 4,
    parameter int FILL   = 10,
    localparam int LW    = 48
) (
    input  logic [ITW-1:0] iters,
    input  logic [FW-1:0]  frame,
    input  logic [KW-1:0]  klog,
    output logic [31:0]    cycles
);
    logic [LW-1:0] prod;
    logic [LW-1:0] rnd;

    always_comb begin
        prod   = LW'(NINSTR) * LW'(iters) * LW'(frame >> 1);
        rnd    = prod + ((LW'(1) << klog) - LW'(1));
        cycles = 32'((rnd >> klog) + LW'(FILL));
    end
endmodule

// File: rtl/psel_top.sv
module psel_top
    import psel_pkg::*;
#(
    parameter int NSNR      = 4,
    parameter int NBER      = 4,
    parameter int BW        = 8,
    parameter int FW        = 16,
    parameter int CW        = 16,
    parameter int PMAX_LOG2 = 4,
    parameter int NINSTR    = 4,
    parameter int SHUF_PEN  = 1,
    localparam int SNRW = (NSNR > 1) ? $clog2(NSNR) : 1,
    localparam int BERW = (NBER > 1) ? $clog2(NBER) : 1,
    localparam int PW   = PMAX_LOG2 + 1,
    localparam int KW   = (PMAX_LOG2 > 0) ? $clog2(PMAX_LOG2 + 1) : 1,
    localparam int ITW  = BW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tbl_we,
    input  logic [SNRW-1:0] tbl_snr,
    input  logic [BERW-1:0] tbl_ber,
    input  logic [BW-1:0]   tbl_base,
    input  logic [BW-1:0]   tbl_thr,
    input  logic            start,
    input  logic [SNRW-1:0] snr_idx,
    input  logic [BERW-1:0] ber_idx,
    input  logic [FW-1:0]   frame_bits,
    input  logic [CW-1:0]   fclk_mhz,
    input  logic [CW-1:0]   tgt_mbps,
    output logic            busy,
    output logic            done,
    output logic [PW-1:0]   par,
    output logic [PW:0]     nproc,
    output logic [ITW-1:0]  iters,
    output logic            shuffled,
    output logic            fallback,
    output logic [31:0]     latency
);
    localparam logic [KW-1:0] KMAX = KW'(PMAX_LOG2);

    typedef struct packed {
        psel_st_e       st;
        logic [KW-1:0]  k;
        logic           shuf;
        logic [BW-1:0]  base;
        logic [BW-1:0]  thr;
        logic [FW-1:0]  frame;
        logic [CW-1:0]  fclk;
        logic [CW-1:0]  tgt;
        logic [KW-1:0]  res_k;
        logic           res_shuf;
        logic [ITW-1:0] res_it;
        logic           res_fb;
        logic [KW-1:0]  o_k;
        logic           o_shuf;
        logic [ITW-1:0] o_it;
        logic           o_fb;
        logic [31:0]    o_lat;
        logic           done;
    } psel_state_t;

    psel_state_t s_d, s_q;

    logic [BW-1:0]  rd_base, rd_thr;
    logic [ITW-1:0] ev_iter;
    logic           ev_meets;
    logic [31:0]    lat_cyc;
    logic [PW-1:0]  cand_par;

    assign cand_par = PW'(1) << s_q.k;

    psel_table #(.NSNR(NSNR), .NBER(NBER), .BW(BW)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .wsnr  (tbl_snr),
        .wber  (tbl_ber),
        .wbase (tbl_base),
        .wthr  (tbl_thr),
        .rsnr  (snr_idx),
        .rber  (ber_idx),
        .rbase (rd_base),
        .rthr  (rd_thr)
    );

    psel_eval #(.BW(BW), .PW(PW), .CW(CW), .NINSTR(NINSTR), .PEN(SHUF_PEN)) u_eval (
        .base  (s_q.base),
        .thr   (s_q.thr),
        .par   (cand_par),
        .shuf  (s_q.shuf),
        .fclk  (s_q.fclk),
        .tgt   (s_q.tgt),
        .niter (ev_iter),
        .meets (ev_meets)
    );

    psel_lat #(.ITW(ITW), .FW(FW), .KW(KW), .NINSTR(NINSTR), .FILL(10)) u_lat (
        .iters  (s_q.res_it),
        .frame  (s_q.frame),
        .klog   (s_q.res_k),
        .cycles (lat_cyc)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st    = ST_EVAL;
                    s_d.k     = '0;
                    s_d.shuf  = 1'b0;
                    s_d.base  = rd_base;
                    s_d.thr   = rd_thr;
                    s_d.frame = frame_bits;
                    s_d.fclk  = fclk_mhz;
                    s_d.tgt   = tgt_mbps;
                end
            end
            ST_EVAL: begin
                if (ev_meets || (s_q.shuf && s_q.k == KMAX)) begin
                    // first passing candidate, or the last one as fallback
                    s_d.st       = ST_LAT;
                    s_d.res_k    = s_q.k;
                    s_d.res_shuf = s_q.shuf;
                    s_d.res_it   = ev_iter;
                    s_d.res_fb   = !ev_meets;
                end else if (!s_q.shuf) begin
                    s_d.shuf = 1'b1;
                end else begin
                    s_d.shuf = 1'b0;
                    s_d.k    = s_q.k + KW'(1);
                end
            end
            ST_LAT: begin
                s_d.st     = ST_IDLE;
                s_d.o_k    = s_q.res_k;
                s_d.o_shuf = s_q.res_shuf;
                s_d.o_it   = s_q.res_it;
                s_d.o_fb   = s_q.res_fb;
                s_d.o_lat  = lat_cyc;
                s_d.done   = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign par      = PW'(1) << s_q.o_k;
    assign nproc    = (PW + 1)'(par) << 1;
    assign iters    = s_q.o_it;
    assign shuffled = s_q.o_shuf;
    assign fallback = s_q.o_fb;
    assign latency  = s_q.o_lat;
endmodule

// File: rtl/psel_chk.sv
module psel_chk #(
    parameter int PW  = 5,
    parameter int ITW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [PW-1:0]  par,
    input logic [PW:0]    nproc,
    input logic [ITW-1:0] iters,
    input logic           shuffled,
    input logic           fallback,
    input logic [31:0]    latency
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || ($stable(par) && $stable(iters) && $stable(shuffled)
                           && $stable(fallback) && $stable(latency))));

    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_fallback_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fallback) |-> (shuffled && par[PW-1]));

    p_par_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(par) == 1);

    p_nproc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nproc[PW:1] == par && !nproc[0]));

    p_iter_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iters != '0));

    p_latency_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (latency >= 32'd10));
endmodule

bind psel_top psel_chk #(.PW(PW), .ITW(ITW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .par      (par),
    .nproc    (nproc),
    .iters    (iters),
    .shuffled (shuffled),
    .fallback (fallback),
    .latency  (latency)
);

// File: tb/tb_psel_top.sv
module tb_psel_top;
    localparam int CLK_PERIOD = 10;
    localparam int NBER = 4;
    localparam int PMAX_LOG2 = 4;
    localparam int PEN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_snr = '0, tbl_ber = '0;
    logic [7:0]  tbl_base = '0, tbl_thr = '0;
    logic        start = 1'b0;
    logic [1:0]  snr_idx = '0, ber_idx = '0;
    logic [15:0] frame_bits = '0, fclk_mhz = '0, tgt_mbps = '0;
    logic        busy, done, shuffled, fallback;
    logic [4:0]  par;
    logic [5:0]  nproc;
    logic [9:0]  iters;
    logic [31:0] latency;

    int errors = 0;
    int checks = 0;
    int mb[16];
    int mt[16];

    always #(CLK_PERIOD/2) clk = ~clk;

    psel_top dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input int b, input int base, input int thr);
        @(negedge clk);
        tbl_we = 1'b1; tbl_snr = 2'(s); tbl_ber = 2'(b);
        tbl_base = 8'(base); tbl_thr = 8'(thr);
        mb[s*NBER+b] = base; mt[s*NBER+b] = thr;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Expected result from the requirements (R2, R3, R4, R5, R7)
    task automatic model(input int base, input int thr, input int frame, input int f,
                         input int t, output int ep, output int esh, output int eit,
                         output int efb, output longint elat);
        int te;
        bit found;
        te = (thr == 0) ? 1 : thr;
        found = 0;
        for (int k = 0; k <= PMAX_LOG2 && !found; k++) begin
            for (int m = 0; m < 2 && !found; m++) begin
                int p, it;
                p = 1 << k;
                it = base + (p + te - 1) / te + m * PEN;
                if (longint'(f) * p * (m + 1) >= longint'(t) * 4 * it) begin
                    found = 1; ep = p; esh = m; eit = it;
                end
                if (!found && k == PMAX_LOG2 && m == 1) begin
                    ep = p; esh = 1; eit = it;
                end
            end
        end
        efb = found ? 0 : 1;
        elat = (longint'(4) * eit * (frame / 2) + ep - 1) / ep + 10;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        if (!done) chk("R8 watchdog done", 0, 1);
    endtask

    task automatic pulse_start(input int s, input int b, input int frame, input int f, input int t);
        @(negedge clk);
        start = 1'b1; snr_idx = 2'(s); ber_idx = 2'(b);
        frame_bits = 16'(frame); fclk_mhz = 16'(f); tgt_mbps = 16'(t);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_res(input string req, input int base, input int thr, input int frame,
                             input int f, input int t);
        int ep, esh, eit, efb;
        longint elat;
        model(base, thr, frame, f, t, ep, esh, eit, efb, elat);
        chk({req, " par"}, par, ep);
        chk({req, " shuffled"}, shuffled, esh);
        chk({req, " iters"}, iters, eit);
        chk({req, " fallback R5"}, fallback, efb);
        chk({req, " nproc R6"}, nproc, 2 * ep);
        chk({req, " latency R7"}, latency, elat);
    endtask

    task automatic run(input string req, input int s, input int b, input int frame,
                       input int f, input int t);
        pulse_start(s, b, frame, f, t);
        chk({req, " busy R8"}, busy, 1);
        wait_done();
        check_res(req, mb[s*NBER+b], mt[s*NBER+b], frame, f, t);
        @(negedge clk);
        chk({req, " done pulse R8"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 par", par, 1);
        chk("R1 nproc", nproc, 2);
        chk("R1 fallback", fallback, 0);
        chk("R1 iters", iters, 0);
        chk("R1 latency", latency, 0);
    endtask

    task automatic t_serial_first();
        wr(0, 0, 6, 4);
        run("R4 serial P1", 0, 0, 2048, 100, 3);
        chk("R4 expect P1 serial", {27'd0, par} + shuffled, 1);
    endtask

    task automatic t_growth();
        run("R3 grow P4", 0, 0, 2048, 100, 14);
        chk("R4 P4 serial chosen", par, 4);
        run("R3 shuffled P2", 0, 0, 2048, 100, 12);
        chk("R4 shuffled at P2", shuffled, 1);
    endtask

    task automatic t_fallback();
        run("R5 unreachable", 0, 0, 1000, 100, 1000);
        chk("R5 flag", fallback, 1);
    endtask

    task automatic t_thr_zero();
        wr(1, 2, 5, 0);
        run("R2 thr zero", 1, 2, 999, 200, 20);
    endtask

    task automatic t_busy_start();
        pulse_start(0, 0, 4096, 100, 14);
        @(negedge clk);
        start = 1'b1; tgt_mbps = 16'd1; frame_bits = 16'd64;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_res("R9 start while busy", 6, 4, 4096, 100, 14);
        repeat (4) @(negedge clk);
        check_res("R8 hold after done", 6, 4, 4096, 100, 14);
    endtask

    task automatic t_collide();
        // write to entry (0,0) in the same cycle the search is accepted
        @(negedge clk);
        tbl_we = 1'b1; tbl_snr = 2'd0; tbl_ber = 2'd0; tbl_base = 8'd2; tbl_thr = 8'd1;
        start = 1'b1; snr_idx = 2'd0; ber_idx = 2'd0;
        frame_bits = 16'd512; fclk_mhz = 16'd100; tgt_mbps = 16'd14;
        @(negedge clk);
        tbl_we = 1'b0; start = 1'b0;
        wait_done();
        check_res("R10 old entry used", 6, 4, 512, 100, 14);
        mb[0] = 2; mt[0] = 1;
        run("R10 new entry used", 0, 0, 512, 100, 14);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mb[i] = 0; mt[i] = 0; end
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_serial_first();
        t_growth();
        t_fallback();
        t_thr_zero();
        t_busy_start();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule